// File: doc/BRIEF.md
# Stochastic Multirate Pink Noise Generator

The block turns a stream of white Gaussian samples into flicker (1/f) noise. It holds 32 stored samples and outputs their sum. On every clock it accepts one fresh Gaussian sample and one word of 31 uniform random bits. The random word chooses which stored sample the fresh one replaces. Slot n is chosen with probability 2^-(n+1), so slot 0 changes about every second cycle and the high slots change very rarely. Summing terms that are refreshed at geometrically spaced average rates gives a spectrum that falls by 3 dB per octave.

The slot index is the number of trailing zeros in the random word. This count is found over five registered halving stages. The Gaussian sample travels alongside the count so that both arrive together. The output is not recomputed from all 32 entries. A running accumulator adds the arriving sample and subtracts the value it overwrites, which keeps the output exactly equal to the sum of the stored entries. A word of all zeros would select slot 31 at twice its intended rate. Such words therefore refresh slot 31 on alternate occurrences only. Both random sources lie outside the block.

Top module: `pink_noise_acc`

## Requirements
- R1: While rst_n is low, and immediately after it rises, pink_o is 0. Reset also clears all 32 stored entries and the alternation state for all-zero words, so the first write after reset to any slot raises pink_o by exactly the written value.
- R2: For a nonzero rnd_i word, the selected slot is the bit index of its lowest set bit. Bit 0 is the least significant bit, so the slot lies between 0 and 30. Bits above the lowest set bit have no effect on the choice.
- R3: A white_i/rnd_i pair sampled on one rising edge first affects pink_o after the sixth rising edge, counting the sampling edge as the first. A new pair is accepted on every edge.
- R4: A write changes pink_o by the new sample minus the value previously held in the selected slot. pink_o therefore always equals the signed sum of the 32 stored 20-bit entries.
- R5: An rnd_i word of all zeros writes slot 31 only on every second occurrence. The first all-zero word after reset leaves pink_o unchanged, the second writes slot 31, and the pattern repeats.
- R6: pink_o never wraps. With every slot holding +524287 it reads +16777184, and with every slot holding -524288 it reads -16777216.
- R7: Writes to the same slot on consecutive edges chain correctly. Each write removes the value left by the one before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| white_i | input | 20 | Signed white Gaussian sample, one per cycle |
| rnd_i | input | 31 | Uniform random bits; their trailing-zero count picks the slot |
| pink_o | output | 25 | Signed running sum of the 32 stored samples |

## Verification
The hardest states to reach from the ports are those involving the rare slots, slot 31 and the slots near 30. Uniform random words select these slots only about once in a billion cycles. The stimulus therefore builds words directly: a single set bit placed at each position, words with noise above a chosen lowest set bit, and pairs of all-zero words. This fills every slot with large values, reaches both extremes of the sum, and exercises the alternation for all-zero words. A long run follows in which the random words are masked to a random lowest position, so that high slots keep changing.

// File: rtl/pink_pkg.sv
package pink_pkg;

    localparam int unsigned PINK_SAMPLE_W = 20;
    localparam int unsigned PINK_PTR_W    = 5;

    // Reference count of zero bits below the first set bit of a word of the
    // given width; returns the width for an all-zero word.
    function automatic int unsigned low_zero_run(input logic [63:0] w,
                                                 input int unsigned width);
        int unsigned n;
        n = width;
        for (int i = width - 1; i >= 0; i--) begin
            if (w[i]) n = i;
        end
        return n;
    endfunction

endpackage

// File: rtl/pink_tz_stage.sv
// One halving step of the pipelined trailing-zero count. The sample that
// travels with the random word is delayed alongside it.
module pink_tz_stage #(
    parameter int unsigned RND_W    = 31,
    parameter int unsigned PTR_W    = 5,
    parameter int unsigned SAMPLE_W = 20,
    parameter int unsigned IDX      = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [RND_W-1:0]           bits_i,
    input  logic [PTR_W-1:0]           tz_i,
    input  logic signed [SAMPLE_W-1:0] smp_i,
    output logic [RND_W-1:0]           bits_o,
    output logic [PTR_W-1:0]           tz_o,
    output logic signed [SAMPLE_W-1:0] smp_o
);
    localparam int unsigned HALF = 1 << (PTR_W - 1 - IDX);
    localparam logic [RND_W-1:0] LOW_MASK  = RND_W'((64'd1 << HALF) - 64'd1);
    localparam logic [RND_W-1:0] KEEP_MASK = RND_W'((64'd1 << (HALF - 1)) - 64'd1);

    typedef struct packed {
        logic [RND_W-1:0]           bits;
        logic [PTR_W-1:0]           tz;
        logic signed [SAMPLE_W-1:0] smp;
    } stage_t;

    stage_t st_d, st_q;
    logic   low_clear;
    logic   unused_tz_msb;

    assign unused_tz_msb = tz_i[PTR_W-1];

    always_comb begin
        low_clear = (bits_i & LOW_MASK) == '0;
        st_d.bits = low_clear ? (bits_i >> HALF) : (bits_i & KEEP_MASK);
        st_d.tz   = {tz_i[PTR_W-2:0], low_clear};
        st_d.smp  = smp_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_o = st_q.bits;
    assign tz_o   = st_q.tz;
    assign smp_o  = st_q.smp;

endmodule

// File: rtl/pink_slot_mem.sv
// Slot storage: combinational read, write on the clock edge, cleared by reset.
module pink_slot_mem #(
    parameter int unsigned PTR_W  = 5,
    parameter int unsigned DATA_W = 20,
    localparam int unsigned SLOTS = 1 << PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [PTR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [SLOTS-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[addr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/pink_noise_acc.sv
module pink_noise_acc
    import pink_pkg::*;
#(
    parameter int unsigned SAMPLE_W = PINK_SAMPLE_W,
    parameter int unsigned PTR_W    = PINK_PTR_W,
    localparam int unsigned SLOTS   = 1 << PTR_W,
    localparam int unsigned RND_W   = SLOTS - 1,
    localparam int unsigned SUM_W   = SAMPLE_W + PTR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] white_i,
    input  logic [RND_W-1:0]           rnd_i,
    output logic signed [SUM_W-1:0]    pink_o
);
    typedef struct packed {
        logic signed [SUM_W-1:0] acc;
        logic                    tog;
    } top_t;

    logic [RND_W-1:0]           bits_arr [PTR_W+1];
    logic [PTR_W-1:0]           tz_arr   [PTR_W+1];
    logic signed [SAMPLE_W-1:0] smp_arr  [PTR_W+1];

    assign bits_arr[0] = rnd_i;
    assign tz_arr[0]   = '0;
    assign smp_arr[0]  = white_i;

    for (genvar g = 0; g < PTR_W; g++) begin : g_tz
        pink_tz_stage #(
            .RND_W   (RND_W),
            .PTR_W   (PTR_W),
            .SAMPLE_W(SAMPLE_W),
            .IDX     (g)
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .bits_i(bits_arr[g]),
            .tz_i  (tz_arr[g]),
            .smp_i (smp_arr[g]),
            .bits_o(bits_arr[g+1]),
            .tz_o  (tz_arr[g+1]),
            .smp_o (smp_arr[g+1])
        );
    end

    logic                       unused_tail_bits;
    logic [PTR_W-1:0]           tail_tz;
    logic signed [SAMPLE_W-1:0] tail_smp;
    logic signed [SAMPLE_W-1:0] old_val;
    logic [SAMPLE_W-1:0]        mem_rdata;
    logic                       all_zero;
    logic                       wr_en;
    logic                       tog_q;
    top_t                       top_d, top_q;

    // After the last halving nothing of the word is left.
    assign unused_tail_bits = |bits_arr[PTR_W];
    assign tail_tz  = tz_arr[PTR_W];
    assign tail_smp = smp_arr[PTR_W];
    assign old_val  = mem_rdata;

    pink_slot_mem #(
        .PTR_W (PTR_W),
        .DATA_W(SAMPLE_W)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (wr_en),
        .addr_i (tail_tz),
        .wdata_i(tail_smp),
        .rdata_o(mem_rdata)
    );

    // An all-ones count only arises from an all-zero word; such words refresh
    // the top slot on every second occurrence.
    always_comb begin
        all_zero = tail_tz == '1;
        wr_en    = !all_zero || top_q.tog;
        top_d    = top_q;
        if (all_zero) begin
            top_d.tog = !top_q.tog;
        end
        if (wr_en) begin
            top_d.acc = top_q.acc + SUM_W'(tail_smp) - SUM_W'(old_val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign tog_q  = top_q.tog;
    assign pink_o = top_q.acc;

endmodule

// File: rtl/pink_noise_acc_chk.sv
module pink_noise_acc_chk
    import pink_pkg::*;
#(
    parameter int unsigned SAMPLE_W = PINK_SAMPLE_W,
    parameter int unsigned PTR_W    = PINK_PTR_W,
    localparam int unsigned SLOTS   = 1 << PTR_W,
    localparam int unsigned RND_W   = SLOTS - 1,
    localparam int unsigned SUM_W   = SAMPLE_W + PTR_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [RND_W-1:0]        rnd_i,
    input logic signed [SUM_W-1:0] pink_o,
    input logic [PTR_W-1:0]        tail_tz,
    input logic                    wr_en,
    input logic                    tog_q
);
    localparam longint HI_LIM = longint'(SLOTS) * ((longint'(1) << (SAMPLE_W - 1)) - 1);
    localparam longint LO_LIM = -(longint'(SLOTS) * (longint'(1) << (SAMPLE_W - 1)));

    logic [7:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 8'hFF) begin
            age_q <= age_q + 8'd1;
        end
    end

    // R1
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pink_o == '0);

    // R2
    a_r2_slot_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q > 8'(PTR_W)) |->
        (tail_tz == PTR_W'(low_zero_run(64'($past(rnd_i, PTR_W)), RND_W))));

    // R3
    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pink_o));

    // R5
    a_r5_zero_word_skip: assert property (@(posedge clk) disable iff (!rst_n)
        ((tail_tz == '1) && !tog_q) |=> $stable(pink_o));

    // R6
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(pink_o) <= HI_LIM) && (longint'(pink_o) >= LO_LIM));

endmodule

bind pink_noise_acc pink_noise_acc_chk #(
    .SAMPLE_W(SAMPLE_W),
    .PTR_W   (PTR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rnd_i  (rnd_i),
    .pink_o (pink_o),
    .tail_tz(tail_tz),
    .wr_en  (wr_en),
    .tog_q  (tog_q)
);

// File: tb/pink_noise_acc_test.sv
`timescale 1ns/1ps
module pink_noise_acc_test;

    localparam int LAT = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [19:0] white = '0;
    logic [30:0]        rnd = 31'h4000_0000;
    logic signed [24:0] pink;

    int     n_checks = 0;
    int     n_fail = 0;
    int     model_mem [32];
    bit     model_tog;
    longint model_sum;
    longint pipe [LAT];
    bit [31:0] xs_state = 32'h1234_5678;

    always #2.5 clk = ~clk;

    pink_noise_acc uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .white_i(white),
        .rnd_i  (rnd),
        .pink_o (pink)
    );

    function automatic bit [31:0] xs_next(input bit [31:0] s);
        bit [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic int lowest_set(input bit [30:0] w);
        for (int i = 0; i < 31; i++) begin
            if (w[i]) return i;
        end
        return 31;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 32; i++) model_mem[i] = 0;
        for (int i = 0; i < LAT; i++) pipe[i] = 0;
        model_tog = 1'b0;
        model_sum = 0;
    endtask

    task automatic model_apply(input int w, input bit [30:0] r);
        int  s;
        bit  do_wr;
        do_wr = 1'b1;
        if (r == '0) begin
            do_wr = model_tog;
            model_tog = !model_tog;
            s = 31;
        end else begin
            s = lowest_set(r);
        end
        if (do_wr) begin
            model_sum = model_sum + w - model_mem[s];
            model_mem[s] = w;
        end
        for (int k = LAT - 1; k > 0; k--) pipe[k] = pipe[k-1];
        pipe[0] = model_sum;
    endtask

    // One cycle: drive, let the edge take it, compare the output after it.
    task automatic step(input int w, input bit [30:0] r, input string req);
        @(negedge clk);
        white = 20'(w);
        rnd   = r;
        @(posedge clk);
        model_apply(w, r);
        #1;
        check(req, longint'(pink), pipe[LAT-1]);
    endtask

    // Rewrites slot 30 with the value it already holds.
    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(model_mem[30], 31'h4000_0000, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        white = '0;
        rnd   = 31'h4000_0000;
        model_clear();
        repeat (2) @(posedge clk);
        #1;
        check("R1 output held at zero in reset", longint'(pink), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(posedge clk);
        #1;
        check("R1 output after reset release", longint'(pink), 0);
    endtask

    task automatic t_latency();
        do_reset();
        step(1000, 31'h1, "R3");
        for (int i = 1; i < LAT; i++) begin
            idle(1, "R3");
            check("R3 output before latency", longint'(pink), (i < LAT - 1) ? 0 : 1000);
        end
        step(-250, 31'h2, "R3");
        step(40, 31'h1, "R3");
        idle(LAT, "R3");
        check("R3 back-to-back accepted", longint'(pink), 1000 - 250 + 40 - 1000);
    endtask

    task automatic t_slot_select();
        do_reset();
        for (int n = 0; n < 31; n++) begin
            step(n * 1000 + 7, 31'(1) << n, "R2");
        end
        idle(LAT, "R2");
        check("R2 sum after one write per slot", longint'(pink), 465000 + 31 * 7);
        // High noise above the lowest set bit must not change the slot.
        for (int n = 0; n < 30; n++) begin
            step(0, 31'h7FFF_FFFF << n, "R2");
        end
        idle(LAT, "R2");
        check("R2 slots 0..29 cleared with noisy high bits", longint'(pink), 30007);
        check("R2 model slot 30 held", longint'(model_mem[30]), 30007);
    endtask

    task automatic t_zero_word();
        do_reset();
        step(777, '0, "R5");
        idle(LAT, "R5");
        check("R5 first zero word ignored", longint'(pink), 0);
        step(555, '0, "R5");
        idle(LAT, "R5");
        check("R5 second zero word writes slot 31", longint'(pink), 555);
        step(-3, '0, "R5");
        step(-9, '0, "R5");
        idle(LAT, "R5");
        check("R5 alternation replaces slot 31", longint'(pink), -9);
        step(12, 31'h4000_0000, "R5");
        idle(LAT, "R5");
        check("R5 slot 30 distinct from slot 31", longint'(pink), 3);
    endtask

    task automatic t_extremes();
        do_reset();
        for (int n = 0; n < 31; n++) step(524287, 31'(1) << n, "R6");
        step(524287, '0, "R6");
        step(524287, '0, "R6");
        idle(LAT, "R6");
        check("R6 full positive sum", longint'(pink), 16777184);
        for (int n = 0; n < 31; n++) step(-524288, 31'(1) << n, "R6");
        step(-524288, '0, "R6");
        step(-524288, '0, "R6");
        idle(LAT, "R6");
        check("R6 full negative sum", longint'(pink), -16777216);
    endtask

    task automatic t_mid_reset();
        step(321, 31'h20, "R1");
        do_reset();
        step(77, 31'h20, "R1");
        idle(LAT, "R1");
        check("R1 memory cleared by reset", longint'(pink), 77);
        step(5, '0, "R1");
        idle(LAT, "R1");
        check("R1 zero-word state cleared by reset", longint'(pink), 77);
    endtask

    task automatic t_same_slot();
        do_reset();
        step(9, 31'h1, "R7");
        step(10, 31'h8, "R7");
        step(20, 31'h108, "R7");
        step(30, 31'h7FFF_FFF8, "R7");
        idle(LAT, "R7");
        check("R7 chained writes to slot 3", longint'(pink), 39);
    endtask

    task automatic t_random();
        bit [31:0] x;
        bit [31:0] y;
        bit [30:0] r;
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            xs_state = xs_next(xs_state);
            x = xs_state;
            xs_state = xs_next(xs_state);
            y = xs_state;
            r = x[30:0] & (31'h7FFF_FFFF << (y % 31));
            if (y[31:27] == 5'd0) r = '0;
            step(int'($signed(y[19:0])), r, "R4");
        end
        idle(LAT, "R4");
        check("R4 running sum matches stored entries", longint'(pink), model_sum);
    endtask

    initial begin
        model_clear();
        t_reset_state();
        t_latency();
        t_slot_select();
        t_zero_word();
        t_extremes();
        t_mid_reset();
        t_same_slot();
        t_random();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule